// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns characters handed over by a processor into frames on a single asynchronous output line. A write places a character in a holding register. Whenever the shift stage is empty, the character moves across and its frame starts on the next bit-rate tick. Because of the two stages, the processor can supply the next character while the current one is still being sent, and frames follow one another with no idle gap. The bit-rate tick is a one-cycle pulse from an external rate generator. Every bit stays on the line for one tick period.

A word-length control picks between plain 8-bit frames and 9-bit frames. In a 9-bit frame, the extra bit is a value supplied by software and captured with the character. The block never computes parity; software can place a parity value in the extra bit or in the top data bit.

Two sticky flags report the state of the block:
- The holding-empty flag sets when the holding register hands its character to the shift stage. It also drives the interrupt request.
- The line-finished flag sets when a stop bit completes and nothing is waiting.

Software clears both flags by pulsing the status-read strobe and then, in a later cycle, writing the data register.

Top module: `buffered_serial_tx`

## Requirements
- R1: After reset, `txd` is 1, `dre_flag` is 1, `tc_flag` is 1 and `irq` is 1. The line is 1 whenever no frame bit is being driven.
- R2: With `mode9` = 0 at write time, the frame is a 0 start bit, then the 8 bits of `wr_data` with bit 0 first, then a 1 stop bit: 10 bits in all.
- R3: With `mode9` = 1 at write time, the value of `bit9` captured with the character is sent between the last data bit and the stop bit: 11 bits in all. No parity is generated; the extra bit is exactly the supplied value.
- R4: `txd` changes only on a clock edge where `bit_tick` is high, so each frame bit lasts exactly one tick period. A frame's start bit begins at the first tick after its character reaches the shift stage.
- R5: A character moves from the holding register to the shift stage as soon as the shift stage has no bits left. A character that is waiting when a stop bit ends starts its start bit on that same tick, with no idle bit in between.
- R6: A `dr_wr` while the holding register is full is ignored. The waiting character is sent unchanged, and the ignored value never appears on the line.
- R7: `dre_flag` becomes 1 one edge after the edge on which the holding register hands its character to the shift stage.
- R8: `tc_flag` becomes 1 one edge after the tick that ends a stop bit while no character is waiting.
- R9: Both flags clear only on a `dr_wr` edge that comes after a `stat_rd` edge with no `dr_wr` between them. A write alone does not clear them, and a status read alone does not clear them. A set event on the same edge wins over the clear.
- R10: `irq` is 1 exactly while `dre_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period from the rate generator |
| dr_wr | input | 1 | Data register write strobe |
| wr_data | input | DATA_W | Character to send |
| mode9 | input | 1 | Word length for this character: 0 = 8 bits, 1 = 9 bits |
| bit9 | input | 1 | Extra bit value for a 9-bit character |
| stat_rd | input | 1 | Status register read strobe |
| txd | output | 1 | Serial line, idle high |
| dre_flag | output | 1 | Sticky holding-register-empty flag |
| tc_flag | output | 1 | Sticky transmission-complete flag |
| irq | output | 1 | Interrupt request, raised while the holding-empty flag is set |

## Verification
Each result has a fixed delay after its stimulus:
- An accepted write fills the holding register on its own edge.
- If the shift stage is empty, the transfer happens on the next edge, and `dre_flag` reads 1 one edge after that.
- The start bit appears on the first tick edge after the transfer. If a stop bit is ending, it appears on that same tick edge instead.
- `tc_flag` rises one edge after the tick that ends the last stop bit.
- A clearing write drops both flags on its own edge.

The bench drives inputs and samples outputs on falling edges. A behavioural queue model steps on each rising edge and applies these delays, and every output is compared with it each cycle. Frame captures detect the start bit and then sample once per tick period, so a bit held too long or too short is also caught.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [1:0] {
      FLG_KEEP = 2'd0,
      FLG_SET  = 2'd1,
      FLG_CLR  = 2'd2
   } flag_act_e;

   // set wins over clear on the same edge
   function automatic flag_act_e flag_action(input logic set_ev, input logic clr_ev);
      if (set_ev)      return FLG_SET;
      else if (clr_ev) return FLG_CLR;
      else             return FLG_KEEP;
   endfunction

   function automatic logic flag_next(input flag_act_e act, input logic cur);
      case (act)
         FLG_SET: return 1'b1;
         FLG_CLR: return 1'b0;
         default: return cur;
      endcase
   endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int DATA_W = 8,
   parameter bit EXT_EN = 1'b1,
   localparam int FW    = DATA_W + 3,
   localparam int LW    = $clog2(FW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_mode9,
   input  logic              wr_bit9,
   input  logic              take,
   output logic              full,
   output logic [FW-1:0]     frm,
   output logic [LW-1:0]     frm_len
);

   localparam logic [LW-1:0] LEN_LONG  = LW'(FW);
   localparam logic [LW-1:0] LEN_SHORT = LW'(FW - 1);

   logic [FW-1:0] frm_nxt;
   logic [LW-1:0] len_nxt;
   logic          accept;

   generate
      if (EXT_EN) begin : g_ext
         always_comb begin
            frm_nxt = {1'b1, (wr_mode9 ? wr_bit9 : 1'b1), wr_data, 1'b0};
            len_nxt = wr_mode9 ? LEN_LONG : LEN_SHORT;
         end
      end else begin : g_std
         logic unused_ext;
         assign unused_ext = wr_mode9 ^ wr_bit9;
         always_comb begin
            frm_nxt = {2'b11, wr_data, 1'b0};
            len_nxt = LEN_SHORT;
         end
      end
   endgenerate

   assign accept = wr_en && !full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full    <= 1'b0;
         frm     <= '1;
         frm_len <= '0;
      end else if (accept) begin
         full    <= 1'b1;
         frm     <= frm_nxt;
         frm_len <= len_nxt;
      end else if (take) begin
         full    <= 1'b0;
      end
   end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
   parameter int DATA_W = 8,
   localparam int FW    = DATA_W + 3,
   localparam int LW    = $clog2(FW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_tick,
   input  logic          hold_full,
   input  logic [FW-1:0] hold_frm,
   input  logic [LW-1:0] hold_len,
   output logic          take,
   output logic          frame_done,
   output logic          on_line,
   output logic          txd
);

   logic [FW-1:0] sh;
   logic [LW-1:0] cnt;
   logic          sh_empty;

   assign sh_empty   = (cnt == '0);
   assign take       = hold_full && sh_empty;
   assign frame_done = bit_tick && sh_empty && on_line && !hold_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh      <= '1;
         cnt     <= '0;
         txd     <= 1'b1;
         on_line <= 1'b0;
      end else if (bit_tick) begin
         if (!sh_empty) begin
            txd     <= sh[0];
            sh      <= {1'b1, sh[FW-1:1]};
            cnt     <= cnt - 1'b1;
            on_line <= 1'b1;
         end else if (hold_full) begin
            // load and launch start bit on the same tick: no gap
            txd     <= hold_frm[0];
            sh      <= {1'b1, hold_frm[FW-1:1]};
            cnt     <= hold_len - 1'b1;
            on_line <= 1'b1;
         end else begin
            txd     <= 1'b1;
            on_line <= 1'b0;
         end
      end else if (take) begin
         sh  <= hold_frm;
         cnt <= hold_len;
      end
   end

endmodule

// File: rtl/sertx_flags.sv
module sertx_flags
   import sertx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic stat_rd,
   input  logic dr_wr,
   input  logic set_dre,
   input  logic set_tc,
   output logic dre,
   output logic tc,
   output logic armed
);

   logic      clr_ev;
   flag_act_e dre_act;
   flag_act_e tc_act;

   assign clr_ev  = dr_wr && armed;
   assign dre_act = flag_action(set_dre, clr_ev);
   assign tc_act  = flag_action(set_tc, clr_ev);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dre   <= 1'b1;
         tc    <= 1'b1;
         armed <= 1'b0;
      end else begin
         dre <= flag_next(dre_act, dre);
         tc  <= flag_next(tc_act, tc);
         if (stat_rd)    armed <= 1'b1;
         else if (dr_wr) armed <= 1'b0;
      end
   end

endmodule

// File: rtl/buffered_serial_tx.sv
module buffered_serial_tx #(
   parameter int DATA_W = 8,
   parameter bit EXT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              dr_wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              mode9,
   input  logic              bit9,
   input  logic              stat_rd,
   output logic              txd,
   output logic              dre_flag,
   output logic              tc_flag,
   output logic              irq
);

   localparam int FW = DATA_W + 3;
   localparam int LW = $clog2(FW + 1);

   generate
      if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
         $error("buffered_serial_tx: DATA_W must lie in 5..16");
      end
   endgenerate

   logic          hold_full;
   logic [FW-1:0] hold_frm;
   logic [LW-1:0] hold_len;
   logic          take;
   logic          frame_done;
   logic          on_line;
   logic          armed;

   sertx_hold #(.DATA_W(DATA_W), .EXT_EN(EXT_EN)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (dr_wr),
      .wr_data  (wr_data),
      .wr_mode9 (mode9),
      .wr_bit9  (bit9),
      .take     (take),
      .full     (hold_full),
      .frm      (hold_frm),
      .frm_len  (hold_len)
   );

   sertx_shift #(.DATA_W(DATA_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_tick   (bit_tick),
      .hold_full  (hold_full),
      .hold_frm   (hold_frm),
      .hold_len   (hold_len),
      .take       (take),
      .frame_done (frame_done),
      .on_line    (on_line),
      .txd        (txd)
   );

   sertx_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_rd (stat_rd),
      .dr_wr   (dr_wr),
      .set_dre (take),
      .set_tc  (frame_done),
      .dre     (dre_flag),
      .tc      (tc_flag),
      .armed   (armed)
   );

   assign irq = dre_flag;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
   parameter int DATA_W = 8,
   localparam int FW    = DATA_W + 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bit_tick,
   input logic          dr_wr,
   input logic          txd,
   input logic          dre,
   input logic          tc,
   input logic          hold_full,
   input logic [FW-1:0] hold_frm,
   input logic          take,
   input logic          armed,
   input logic          on_line
);

   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !on_line |-> txd);

   p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && !on_line && hold_full) |=> !txd);

   p_hold_between_ticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(txd));

   p_keep_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_full && !take) |=> (hold_full && $stable(hold_frm)));

   p_dre_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dre) |-> $past(take));

   p_tc_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc) |-> ($past(bit_tick) && !$past(hold_full)));

   p_dre_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dre) |-> ($past(dr_wr) && $past(armed)));

   p_tc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tc) |-> ($past(dr_wr) && $past(armed)));

endmodule

bind buffered_serial_tx sertx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_tick  (bit_tick),
   .dr_wr     (dr_wr),
   .txd       (txd),
   .dre       (dre_flag),
   .tc        (tc_flag),
   .hold_full (hold_full),
   .hold_frm  (hold_frm),
   .take      (take),
   .armed     (armed),
   .on_line   (on_line)
);

// File: tb/buffered_serial_tx_bench.sv
`timescale 1ns/1ps
module buffered_serial_tx_bench;

   localparam int TD = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       dr_wr = 1'b0;
   logic [7:0] wr_data = '0;
   logic       mode9 = 1'b0;
   logic       bit9 = 1'b0;
   logic       stat_rd = 1'b0;
   logic       txd, dre_flag, tc_flag, irq;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   buffered_serial_tx u_buffered_serial_tx (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .dr_wr(dr_wr),
      .wr_data(wr_data), .mode9(mode9), .bit9(bit9), .stat_rd(stat_rd),
      .txd(txd), .dre_flag(dre_flag), .tc_flag(tc_flag), .irq(irq)
   );

   // tick generator
   initial begin
      int c = 0;
      forever begin
         @(negedge clk);
         bit_tick = (c == TD - 1);
         c = (c == TD - 1) ? 0 : c + 1;
      end
   end

   // behavioural reference model
   bit hold_q[$];
   bit sh_q[$];
   bit m_hold = 0, m_busy = 0, m_txd = 1, m_dre = 1, m_tc = 1, m_arm = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         hold_q.delete(); sh_q.delete();
         m_hold = 0; m_busy = 0; m_txd = 1; m_dre = 1; m_tc = 1; m_arm = 0;
      end else begin
         bit set_d, set_t, clr, acc;
         set_d = 0; set_t = 0;
         clr = dr_wr && m_arm;
         acc = dr_wr && !m_hold;
         if (bit_tick) begin
            if (sh_q.size() > 0) begin
               m_txd = sh_q.pop_front(); m_busy = 1;
            end else if (m_hold) begin
               sh_q = hold_q; m_hold = 0; set_d = 1;
               m_txd = sh_q.pop_front(); m_busy = 1;
            end else begin
               m_txd = 1;
               if (m_busy) begin m_busy = 0; set_t = 1; end
            end
         end else if (sh_q.size() == 0 && m_hold) begin
            sh_q = hold_q; m_hold = 0; set_d = 1;
         end
         if (acc) begin
            hold_q.delete();
            hold_q.push_back(1'b0);
            for (int i = 0; i < 8; i++) hold_q.push_back(wr_data[i]);
            if (mode9) hold_q.push_back(bit9);
            hold_q.push_back(1'b1);
            m_hold = 1;
         end
         if (stat_rd) m_arm = 1; else if (dr_wr) m_arm = 0;
         m_dre = set_d ? 1'b1 : (clr ? 1'b0 : m_dre);
         m_tc  = set_t ? 1'b1 : (clr ? 1'b0 : m_tc);
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison with the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R4 txd vs model", txd, m_txd);
         check("R7 dre_flag vs model", dre_flag, m_dre);
         check("R8 tc_flag vs model", tc_flag, m_tc);
         check("R10 irq vs model", irq, m_dre);
      end
   end

   task automatic do_write(input logic [7:0] d, input logic m9, input logic b9);
      @(negedge clk);
      dr_wr = 1; wr_data = d; mode9 = m9; bit9 = b9;
      @(negedge clk);
      dr_wr = 0;
   endtask

   task automatic do_status();
      @(negedge clk);
      stat_rd = 1;
      @(negedge clk);
      stat_rd = 0;
   endtask

   // wait for a start bit, then sample once per tick period
   task automatic capture(input int n, output logic [31:0] cap);
      cap = '1;
      do @(negedge clk); while (txd !== 1'b0);
      cap[0] = txd;
      for (int i = 1; i < n; i++) begin
         repeat (TD) @(negedge clk);
         cap[i] = txd;
      end
   endtask

   task automatic check_vec(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired, run hung");
      finish_run();
   end

   initial begin
      logic [31:0] cap;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 txd idle", txd, 1'b1);
      check("R1 dre_flag", dre_flag, 1'b1);
      check("R1 tc_flag", tc_flag, 1'b1);
      check("R1 irq", irq, 1'b1);

      // R2 plain 8-bit frame
      fork
         capture(10, cap);
         do_write(8'hA5, 1'b0, 1'b0);
      join
      check_vec("R2 8-bit frame", cap & 32'h3FF, {22'h0, 1'b1, 8'hA5, 1'b0});
      repeat (3 * TD) @(negedge clk);
      check("R1 line idle after frame", txd, 1'b1);

      // R3 9-bit frames: extra bit is the supplied value, no parity
      fork
         capture(11, cap);
         do_write(8'h3C, 1'b1, 1'b1);
      join
      check_vec("R3 9-bit frame bit9=1", cap & 32'h7FF, {21'h0, 1'b1, 1'b1, 8'h3C, 1'b0});
      repeat (3 * TD) @(negedge clk);
      fork
         capture(11, cap);
         do_write(8'h01, 1'b1, 1'b0);
      join
      check_vec("R3 9-bit frame bit9=0 no parity", cap & 32'h7FF, {21'h0, 1'b1, 1'b0, 8'h01, 1'b0});
      repeat (3 * TD) @(negedge clk);

      // R5 back-to-back frames without gap, R6 write while full ignored
      fork
         capture(20, cap);
         begin
            do_write(8'hF0, 1'b0, 1'b0);
            repeat (3) @(negedge clk);
            do_write(8'h5A, 1'b0, 1'b0);
            do_write(8'hC3, 1'b0, 1'b0);
         end
      join
      check_vec("R5 back-to-back frames", cap & 32'hFFFFF,
                {12'h0, 1'b1, 8'h5A, 1'b0, 1'b1, 8'hF0, 1'b0});
      repeat (4 * TD) @(negedge clk);
      check("R6 ignored write never sent", txd, 1'b1);

      // R9 clear sequence while shifter busy
      do_write(8'h11, 1'b0, 1'b0);
      repeat (2) @(negedge clk);
      do_status();
      do_write(8'h22, 1'b0, 1'b0);
      check("R9 dre cleared by read then write", dre_flag, 1'b0);
      check("R9 tc cleared by read then write", tc_flag, 1'b0);
      check("R10 irq low with dre low", irq, 1'b0);
      repeat (11 * TD) @(negedge clk);
      check("R7 dre set after transfer", dre_flag, 1'b1);
      check("R8 tc still low mid frame", tc_flag, 1'b0);
      repeat (12 * TD) @(negedge clk);
      check("R8 tc set after last stop", tc_flag, 1'b1);

      // R9 write alone, status read alone: no clear
      do_status();
      repeat (3) @(negedge clk);
      check("R9 status read alone keeps dre", dre_flag, 1'b1);
      repeat (12 * TD) @(negedge clk);
      do_write(8'h77, 1'b0, 1'b0);
      check("R9 write after read clears", dre_flag, 1'b0);
      repeat (13 * TD) @(negedge clk);
      do_write(8'h66, 1'b0, 1'b0);
      check("R9 write alone keeps tc", tc_flag, 1'b1);
      repeat (14 * TD) @(negedge clk);
      check("R10 irq follows dre", irq, dre_flag);
      finish_run();
   end

endmodule